// File: doc/BRIEF.md
# PCM Serial Port with Frame Sync Width Detection

This block is the 8-bit serial data port of a voice codec. On the transmit side it takes a parallel code word and sends it on a serial output with its own enable, most significant (sign) bit first. The output is enabled and disabled at set edges of the transmit bit clock. On the receive side it shifts in a serial stream, sign bit first, on falling bit clock edges. After the eighth bit it presents the byte together with a one-cycle valid strobe.

The bit clocks and frame syncs are slow level inputs. The block samples them with a fast system clock and finds their edges. The block measures how long the transmit frame sync stays high and from this picks short-pulse or long-pulse framing. That choice sets when each direction starts a frame. In synchronous operation the receive side uses the transmit bit clock, and the receive bit clock pin is ignored. In asynchronous operation the receive side uses its own bit clock. The word sent in a frame is the one presented at the start of the previous frame.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, tx_oe, tx_dout and rx_valid are 0 and long_mode is 0 (short framing).
- R2: In short framing, when tx_fs is high at a falling tx_bclk edge, the next rising edge raises tx_oe and drives bit 7. Each of the next seven rising edges drives the next lower bit.
- R3: tx_oe stays high for eight bit periods and drops at the first falling tx_bclk edge after the rising edge that drove bit 0. tx_dout is 0 while tx_oe is 0, and it changes only at rising bit clock edges while enabled.
- R4: The word sent in a frame is the tx_word value sampled when the previous frame started. The first frame after reset sends 0x00.
- R5: When tx_fs falls, the number of falling tx_bclk edges it was high for sets the mode. A count of 1 selects short framing (long_mode=0). A count of 3 or more selects long framing (long_mode=1). A count of 2 keeps the current mode. The new mode applies from the next frame.
- R6: In long framing, tx_oe rises with bit 7 at the later of the tx_fs rising edge and a tx_bclk rising edge. If tx_fs rises while tx_bclk is high, that happens at once. Otherwise it happens at the next rising edge. The remaining bits follow on rising edges as in R2.
- R7: In short framing, when rx_fs is high at a falling receive bit clock edge, the next eight falling edges latch bit 7 down to bit 0. One cycle later rx_byte holds the word and rx_valid pulses high for exactly one cycle.
- R8: In long framing, the first falling receive bit clock edge after rx_fs rises latches bit 7, and the next seven latch the rest.
- R9: With sync_mode=1 the receive side is clocked by tx_bclk and rx_bclk has no effect. With sync_mode=0 it is clocked by rx_bclk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 1: receive uses tx_bclk; 0: receive uses rx_bclk |
| tx_bclk | input | 1 | Transmit bit clock (level, sampled) |
| tx_fs | input | 1 | Transmit frame sync |
| tx_word | input | WORD_W | Encoded word for the next frame |
| tx_dout | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Output enable for tx_dout (0 = high impedance) |
| rx_bclk | input | 1 | Receive bit clock (used when sync_mode=0) |
| rx_fs | input | 1 | Receive frame sync |
| rx_din | input | 1 | Serial receive data |
| rx_byte | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe when rx_byte updates |
| long_mode | output | 1 | 1 when long framing is selected |

## Verification
The assertions assume that each bit clock half period spans several system clocks, so that a rising and a falling edge are never detected in the same cycle. They also assume that frame syncs and serial data change only next to a rising bit clock edge and that frames do not overlap. The stimulus holds each bit clock phase for four system clocks. It changes the frame syncs and data at the rising edge, or two clocks later for the delayed frame sync case, and leaves several idle bit periods after each frame. Under these conditions every edge the block sees is unambiguous.

// File: rtl/pcm_sp_pkg.sv
package pcm_sp_pkg;
  typedef enum logic {
    FS_SHORT = 1'b0,
    FS_LONG  = 1'b1
  } fs_mode_e;
endpackage

// File: rtl/pcm_sig_sample.sv
// Samples a vector of slow level inputs; q is the current sample, p the one before.
module pcm_sig_sample #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] p
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
      p <= '0;
    end else begin
      q <= d;
      p <= q;
    end
  end
endmodule

// File: rtl/pcm_mode_detect.sv
// Measures transmit frame sync width in falling bit clock edges.
module pcm_mode_detect
  import pcm_sp_pkg::*;
#(
  parameter int LONG_MIN = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     fall,
  input  logic     fs_lvl,
  output fs_mode_e mode
);
  localparam int CW = $clog2(LONG_MIN + 1);
  localparam logic [CW-1:0] SAT = CW'(LONG_MIN);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= '0;
      mode <= FS_SHORT;
    end else if (fall) begin
      if (fs_lvl) begin
        if (run != SAT) run <= run + 1'b1;
      end else if (run != '0) begin
        if (run == CW'(1))   mode <= FS_SHORT;
        else if (run == SAT) mode <= FS_LONG;
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/pcm_tx_shift.sv
// Transmit framing: start rule per mode, MSB-first shift, enable timing.
module pcm_tx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         long_mode,
  input  logic         rise,
  input  logic         fall,
  input  logic         bclk_lvl,
  input  logic         fs_lvl,
  input  logic         fs_rise,
  input  logic [W-1:0] word,
  output logic         dout,
  output logic         oe
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  logic [W-1:0]  sh;
  logic [W-1:0]  hold;
  logic [CW-1:0] cnt;
  logic          pend;
  logic          go;
  logic          arm;

  always_comb begin
    go  = !oe && ((pend && rise) || (long_mode && fs_rise && bclk_lvl));
    arm = !oe && !pend &&
          ((!long_mode && fall && fs_lvl) || (long_mode && fs_rise && !bclk_lvl));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      hold <= '0;
      cnt  <= '0;
      pend <= 1'b0;
      oe   <= 1'b0;
    end else if (go) begin
      oe   <= 1'b1;
      sh   <= hold;
      hold <= word;
      cnt  <= CW'(1);
      pend <= 1'b0;
    end else if (oe && rise && cnt != LAST) begin
      sh  <= {sh[W-2:0], 1'b0};
      cnt <= cnt + 1'b1;
    end else if (oe && fall && cnt == LAST) begin
      oe  <= 1'b0;
      sh  <= '0;
      cnt <= '0;
    end else if (arm) begin
      pend <= 1'b1;
    end
  end

  assign dout = sh[W-1];
endmodule

// File: rtl/pcm_rx_shift.sv
// Receive framing: arms per mode, latches MSB first on falling edges.
module pcm_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         long_mode,
  input  logic         fall,
  input  logic         fs_lvl,
  input  logic         fs_rise,
  input  logic         din,
  output logic [W-1:0] rx_byte,
  output logic         valid
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      rx_byte <= '0;
      valid   <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!busy) begin
        if ((!long_mode && fall && fs_lvl) || (long_mode && fs_rise)) busy <= 1'b1;
      end else if (fall) begin
        sh <= {sh[W-2:0], din};
        if (cnt == LAST) begin
          rx_byte <= {sh[W-2:0], din};
          valid   <= 1'b1;
          cnt     <= '0;
          busy    <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_sp_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int LONG_MIN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_mode,
  input  logic              tx_bclk,
  input  logic              tx_fs,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_dout,
  output logic              tx_oe,
  input  logic              rx_bclk,
  input  logic              rx_fs,
  input  logic              rx_din,
  output logic [WORD_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              long_mode
);
  localparam int NS = 4;

  logic [NS-1:0] s_q;
  logic [NS-1:0] s_p;
  logic          din_q;
  fs_mode_e      mode;

  logic tx_bclk_lvl, tx_rise, tx_fall, tx_fs_lvl, tx_fs_rise;
  logic rx_own_fall, rx_fall, rx_fs_lvl, rx_fs_rise;

  pcm_sig_sample #(.W(NS)) smp_i (
    .clk (clk),
    .rst (rst),
    .d   ({tx_bclk, tx_fs, rx_bclk, rx_fs}),
    .q   (s_q),
    .p   (s_p)
  );

  always_ff @(posedge clk) begin
    if (rst) din_q <= 1'b0;
    else     din_q <= rx_din;
  end

  always_comb begin
    tx_bclk_lvl = s_q[3];
    tx_rise     = s_q[3] & ~s_p[3];
    tx_fall     = ~s_q[3] & s_p[3];
    tx_fs_lvl   = s_q[2];
    tx_fs_rise  = s_q[2] & ~s_p[2];
    rx_own_fall = ~s_q[1] & s_p[1];
    rx_fs_lvl   = s_q[0];
    rx_fs_rise  = s_q[0] & ~s_p[0];
    rx_fall     = sync_mode ? tx_fall : rx_own_fall;
  end

  pcm_mode_detect #(.LONG_MIN(LONG_MIN)) mode_i (
    .clk    (clk),
    .rst    (rst),
    .fall   (tx_fall),
    .fs_lvl (tx_fs_lvl),
    .mode   (mode)
  );

  assign long_mode = (mode == FS_LONG);

  pcm_tx_shift #(.W(WORD_W)) tx_i (
    .clk       (clk),
    .rst       (rst),
    .long_mode (long_mode),
    .rise      (tx_rise),
    .fall      (tx_fall),
    .bclk_lvl  (tx_bclk_lvl),
    .fs_lvl    (tx_fs_lvl),
    .fs_rise   (tx_fs_rise),
    .word      (tx_word),
    .dout      (tx_dout),
    .oe        (tx_oe)
  );

  pcm_rx_shift #(.W(WORD_W)) rx_i (
    .clk       (clk),
    .rst       (rst),
    .long_mode (long_mode),
    .fall      (rx_fall),
    .fs_lvl    (rx_fs_lvl),
    .fs_rise   (rx_fs_rise),
    .din       (din_q),
    .rx_byte   (rx_byte),
    .valid     (rx_valid)
  );
endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk (
  input logic clk,
  input logic rst,
  input logic tx_rise,
  input logic tx_fall,
  input logic tx_fs_lvl,
  input logic tx_fs_rise,
  input logic long_mode,
  input logic tx_oe,
  input logic tx_dout,
  input logic rx_valid
);
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_mode_on_fs_low_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(long_mode) |-> $past(tx_fall && !tx_fs_lvl));

  assert_oe_drop_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_oe) |-> $past(tx_fall));

  assert_dout_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !tx_oe |-> !tx_dout);

  assert_dout_moves_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_oe && $past(tx_oe) && !$stable(tx_dout)) |-> $past(tx_rise));

  assert_oe_start_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_oe) |-> ($past(tx_rise) || $past(long_mode && tx_fs_rise)));
endmodule

bind pcm_serial_port pcm_serial_port_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .tx_rise    (tx_rise),
  .tx_fall    (tx_fall),
  .tx_fs_lvl  (tx_fs_lvl),
  .tx_fs_rise (tx_fs_rise),
  .long_mode  (long_mode),
  .tx_oe      (tx_oe),
  .tx_dout    (tx_dout),
  .rx_valid   (rx_valid)
);

// File: tb/pcm_serial_port_tb_top.sv
`timescale 1ns/1ps
module pcm_serial_port_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sync_mode = 1'b1;
  logic         tx_bclk = 1'b0;
  logic         tx_fs = 1'b0;
  logic [W-1:0] tx_word = '0;
  logic         tx_dout;
  logic         tx_oe;
  logic         rx_bclk = 1'b0;
  logic         rx_fs = 1'b0;
  logic         rx_din = 1'b0;
  logic [W-1:0] rx_byte;
  logic         rx_valid;
  logic         long_mode;

  int checks = 0;
  int errors = 0;
  int vcnt   = 0;
  logic [W-1:0] vbyte = '0;
  logic [W-1:0] prev_word = '0;
  bit exp_long = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pcm_serial_port #(.WORD_W(W), .LONG_MIN(3)) dut_i (
    .clk(clk), .rst(rst), .sync_mode(sync_mode),
    .tx_bclk(tx_bclk), .tx_fs(tx_fs), .tx_word(tx_word),
    .tx_dout(tx_dout), .tx_oe(tx_oe),
    .rx_bclk(rx_bclk), .rx_fs(rx_fs), .rx_din(rx_din),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .long_mode(long_mode)
  );

  always @(posedge clk) begin
    if (!rst && rx_valid) begin
      vcnt  <= vcnt + 1;
      vbyte <= rx_byte;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One frame of 12 bit periods. len: frame sync width in periods; dly: clocks
  // after the rising edge at which the syncs go high (0 or 2).
  task automatic frame(input int len, input int dly, input logic [W-1:0] nxt,
                       input logic [W-1:0] rxb);
    int off;
    bit lng;
    string treq;
    lng  = exp_long;
    off  = lng ? 0 : 1;
    treq = lng ? "R6/R4" : "R2/R4";
    tx_word = nxt;
    vcnt = 0;
    for (int p = 0; p < 12; p++) begin
      bit on_hi, on_lo;
      logic bitv;
      on_hi = (p >= off) && (p < off + W);
      on_lo = (p >= off) && (p < off + W - 1);
      bitv  = on_hi ? prev_word[W-1-(p-off)] : 1'b0;
      tx_bclk = 1'b1;
      if (!sync_mode) rx_bclk = 1'b1;
      rx_din = on_hi ? rxb[W-1-(p-off)] : 1'b0;
      if (dly == 0) begin
        tx_fs = (p < len);
        rx_fs = (p < len);
      end
      for (int k = 1; k < 4; k++) begin
        @(negedge clk);
        if (dly != 0 && k == dly) begin
          tx_fs = (p < len);
          rx_fs = (p < len);
        end
      end
      @(negedge clk);
      chk(lng ? "R6 oe high phase" : "R3 oe high phase", tx_oe, on_hi);
      chk(treq, tx_dout, bitv);
      tx_bclk = 1'b0;
      if (!sync_mode) rx_bclk = 1'b0;
      repeat (4) @(negedge clk);
      chk("R3 oe low phase", tx_oe, on_lo);
    end
    tx_fs = 1'b0;
    rx_fs = 1'b0;
    chk(lng ? "R8 valid count" : "R7 valid count", vcnt, 1);
    chk(sync_mode ? (lng ? "R8 rx byte" : "R7 rx byte") : "R9 async rx byte", vbyte, rxb);
    if (len == 1) exp_long = 1'b0;
    else if (len >= 3) exp_long = 1'b1;
    chk("R5 mode", long_mode, exp_long);
    prev_word = nxt;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 oe", tx_oe, 0);
    chk("R1 dout", tx_dout, 0);
    chk("R1 valid", rx_valid, 0);
    chk("R1 mode", long_mode, 0);

    frame(1, 0, 8'hA5, 8'h3C);       // R4: first frame sends 0x00
    frame(1, 0, 8'h5A, 8'hC3);
    frame(2, 0, 8'h81, 8'h7E);       // R5: width 2 keeps short
    frame(3, 0, 8'h18, 8'hE7);       // R5: becomes long after this frame
    frame(3, 0, 8'hF0, 8'h0F);       // R6/R8
    frame(4, 2, 8'h33, 8'hCC);       // R6: sync rises mid high phase
    frame(2, 0, 8'h96, 8'h69);       // R5: width 2 keeps long
    sync_mode = 1'b0;
    frame(3, 2, 8'h44, 8'hB2);       // R9 async, long
    frame(1, 0, 8'h01, 8'h80);       // R5: back to short
    sync_mode = 1'b1;

    for (int i = 0; i < 256; i++) begin
      sync_mode = ~i[0];              // R9: odd frames use rx_bclk
      frame(1, 0, i[7:0], 8'(255 - i));
    end
    sync_mode = 1'b1;
    frame(1, 0, 8'h00, 8'h55);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule